// File: doc/BRIEF.md
# Push-Pull Transformer Primary Driver with Dead Time

This block drives the two ends of a centre-tapped transformer primary that feeds an isolated supply. It produces two complementary square waves. Between the end of one phase and the start of the other, both outputs are held low for a fixed number of clock cycles. This gap lets one external switch turn off fully before the other one turns on.

The block divides the system clock down to the switching frequency. The half-period length comes from one of two parameters, selected by a supply-mode input. The defaults at a 250 MHz clock give 500 kHz for the high-supply mode and about 330 kHz for the low-supply mode. The driver switches only while the enable input and the supply-good input are both high. If either one drops, both outputs go low at the next clock edge. The next start always begins with phase A. A change on the mode input is picked up only at a period boundary, so no period is ever cut short.

Top module: `xfdrv_top`

## Requirements
- R1: While reset is asserted and after it is released with the driver stopped, both phase outputs are low.
- R2: The two phase outputs are never high in the same cycle.
- R3: With the mode input high (1 = high-supply mode), each phase is high for HI_HALF-DEAD cycles and one full period lasts 2*HI_HALF cycles.
- R4: With the mode input low (0 = low-supply mode), each phase is high for LO_HALF-DEAD cycles and one full period lasts 2*LO_HALF cycles.
- R5: At every changeover, both outputs are low for exactly DEAD cycles.
- R6: Neither output goes high unless enable and supply-good are both high.
- R7: If enable or supply-good is low at a clock edge, both outputs are low from that edge on.
- R8: After each start, the first output to go high is phase A, and it rises one clock edge after the start condition is sampled.
- R9: The mode input is sampled only when a period begins. A change made during a period leaves that period's lengths unchanged and applies from the next period.
- R10: The phases follow the fixed order A high, gap, B high, gap, and then repeat.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| enable_i | input | 1 | Run request |
| supply_good_i | input | 1 | High once the supply has passed its start-up threshold |
| mode_hi_i | input | 1 | 1 selects the high-supply half period, 0 selects the low-supply half period |
| phase_a_o | output | 1 | Drive for the first end of the primary |
| phase_b_o | output | 1 | Drive for the second end of the primary |

## Verification
A wrong state or a wrong count in the sequencer shows up at the ports within one phase. It appears as a pulse or a gap of the wrong width, as B appearing before A, or as an overlap, and the overlap is flagged in the same cycle. If the mode is latched at the wrong moment, the period during which the mode input changes comes out with the wrong lengths. If the stop gating is wrong, an output stays high one cycle after enable or supply-good drops. The bench measures every high and low run at the ports in both modes, and it stops the block in each phase.

// File: rtl/xfd_pkg.sv
`timescale 1ns/1ps
package xfd_pkg;
    typedef enum logic [2:0] {
        ST_IDLE  = 3'd0,
        ST_A     = 3'd1,
        ST_GAPAB = 3'd2,
        ST_B     = 3'd3,
        ST_GAPBA = 3'd4
    } seq_st_e;
endpackage

// File: rtl/xfd_gate.sv
`timescale 1ns/1ps
module xfd_gate (
    input  logic enable_i,
    input  logic supply_good_i,
    output logic run_o
);
    // R6 R7: switching is allowed only while both qualifiers hold
    always_comb begin
        run_o = enable_i & supply_good_i;
    end
endmodule

// File: rtl/xfd_len.sv
`timescale 1ns/1ps
module xfd_len #(
    parameter int HI_HALF = 250,
    parameter int LO_HALF = 379,
    parameter int DEAD    = 8,
    parameter int CW      = 9
) (
    input  logic          mode_hi_i,
    output logic [CW-1:0] on_len_o
);
    localparam logic [CW-1:0] HI_ON = CW'(HI_HALF - DEAD);
    localparam logic [CW-1:0] LO_ON = CW'(LO_HALF - DEAD);

    always_comb begin
        on_len_o = mode_hi_i ? HI_ON : LO_ON;
    end
endmodule

// File: rtl/xfd_seq.sv
`timescale 1ns/1ps
module xfd_seq
    import xfd_pkg::*;
#(
    parameter int DEAD = 8,
    parameter int CW   = 9
) (
    input  logic          clk_i,
    input  logic          rst_ni,
    input  logic          run_i,
    input  logic          mode_hi_i,
    input  logic [CW-1:0] on_len_i,
    output logic          mode_lat_o,
    output logic          phase_a_o,
    output logic          phase_b_o
);
    localparam logic [CW-1:0] GAP_LAST = CW'(DEAD - 1);

    typedef struct packed {
        seq_st_e       st;
        logic [CW-1:0] cnt;
        logic          mode_hi;
    } seq_t;

    seq_t s_d, s_q;
    logic [CW-1:0] on_last;

    always_comb begin
        on_last = on_len_i - CW'(1);
        s_d     = s_q;
        if (!run_i) begin
            s_d.st  = ST_IDLE;
            s_d.cnt = '0;
        end else begin
            unique case (s_q.st)
                ST_IDLE: begin
                    s_d.st      = ST_A;
                    s_d.cnt     = '0;
                    s_d.mode_hi = mode_hi_i;
                end
                ST_A: begin
                    if (s_q.cnt == on_last) begin
                        s_d.st  = ST_GAPAB;
                        s_d.cnt = '0;
                    end else begin
                        s_d.cnt = s_q.cnt + CW'(1);
                    end
                end
                ST_GAPAB: begin
                    if (s_q.cnt == GAP_LAST) begin
                        s_d.st  = ST_B;
                        s_d.cnt = '0;
                    end else begin
                        s_d.cnt = s_q.cnt + CW'(1);
                    end
                end
                ST_B: begin
                    if (s_q.cnt == on_last) begin
                        s_d.st  = ST_GAPBA;
                        s_d.cnt = '0;
                    end else begin
                        s_d.cnt = s_q.cnt + CW'(1);
                    end
                end
                ST_GAPBA: begin
                    if (s_q.cnt == GAP_LAST) begin
                        s_d.st      = ST_A;
                        s_d.cnt     = '0;
                        s_d.mode_hi = mode_hi_i;
                    end else begin
                        s_d.cnt = s_q.cnt + CW'(1);
                    end
                end
                default: begin
                    s_d.st  = ST_IDLE;
                    s_d.cnt = '0;
                end
            endcase
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            s_q <= '{st: ST_IDLE, cnt: '0, mode_hi: 1'b1};
        end else begin
            s_q <= s_d;
        end
    end

    always_comb begin
        mode_lat_o = s_q.mode_hi;
        phase_a_o  = (s_q.st == ST_A);
        phase_b_o  = (s_q.st == ST_B);
    end
endmodule

// File: rtl/xfdrv_top.sv
`timescale 1ns/1ps
module xfdrv_top #(
    parameter int HI_HALF = 250,
    parameter int LO_HALF = 379,
    parameter int DEAD    = 8
) (
    input  logic clk_i,
    input  logic rst_ni,
    input  logic enable_i,
    input  logic supply_good_i,
    input  logic mode_hi_i,
    output logic phase_a_o,
    output logic phase_b_o
);
    localparam int MAX_HALF = (HI_HALF > LO_HALF) ? HI_HALF : LO_HALF;
    localparam int CW       = $clog2(MAX_HALF + 1);

    logic          run;
    logic          mode_lat;
    logic [CW-1:0] on_len;

    xfd_gate u_gate (
        .enable_i      (enable_i),
        .supply_good_i (supply_good_i),
        .run_o         (run)
    );

    xfd_len #(
        .HI_HALF (HI_HALF),
        .LO_HALF (LO_HALF),
        .DEAD    (DEAD),
        .CW      (CW)
    ) u_len (
        .mode_hi_i (mode_lat),
        .on_len_o  (on_len)
    );

    xfd_seq #(
        .DEAD (DEAD),
        .CW   (CW)
    ) u_seq (
        .clk_i      (clk_i),
        .rst_ni     (rst_ni),
        .run_i      (run),
        .mode_hi_i  (mode_hi_i),
        .on_len_i   (on_len),
        .mode_lat_o (mode_lat),
        .phase_a_o  (phase_a_o),
        .phase_b_o  (phase_b_o)
    );
endmodule

// File: rtl/xfd_chk.sv
`timescale 1ns/1ps
module xfd_chk (
    input logic clk_i,
    input logic rst_ni,
    input logic enable_i,
    input logic supply_good_i,
    input logic phase_a_o,
    input logic phase_b_o
);
    logic a_seen_q;

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            a_seen_q <= 1'b0;
        end else if (!(enable_i && supply_good_i)) begin
            a_seen_q <= 1'b0;
        end else if (phase_a_o) begin
            a_seen_q <= 1'b1;
        end else if (phase_b_o) begin
            a_seen_q <= 1'b0;
        end
    end

    // R2
    no_overlap_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !(phase_a_o && phase_b_o));

    // R5
    gap_after_a_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $fell(phase_a_o) |-> !phase_b_o);

    // R5
    gap_before_b_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $rose(phase_b_o) |-> !$past(phase_a_o));

    // R7
    stop_fast_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !(enable_i && supply_good_i) |=> (!phase_a_o && !phase_b_o));

    // R8
    a_first_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $rose(phase_b_o) |-> a_seen_q);
endmodule

bind xfdrv_top xfd_chk u_chk (
    .clk_i         (clk_i),
    .rst_ni        (rst_ni),
    .enable_i      (enable_i),
    .supply_good_i (supply_good_i),
    .phase_a_o     (phase_a_o),
    .phase_b_o     (phase_b_o)
);

// File: tb/test_xfdrv_top.sv
`timescale 1ns/1ps
module test_xfdrv_top;
    localparam int HI_HALF = 250;
    localparam int LO_HALF = 379;
    localparam int DEAD    = 8;

    typedef struct packed {
        logic mode;
        int   on_len;
        int   gap;
        int   period;
    } vec_t;

    localparam vec_t VEC [4] = '{
        '{1'b1, HI_HALF - DEAD, DEAD, 2 * HI_HALF},
        '{1'b0, LO_HALF - DEAD, DEAD, 2 * LO_HALF},
        '{1'b1, HI_HALF - DEAD, DEAD, 2 * HI_HALF},
        '{1'b0, LO_HALF - DEAD, DEAD, 2 * LO_HALF}
    };

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic en = 1'b0;
    logic sg = 1'b0;
    logic mode_hi = 1'b1;
    logic pa, pb;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;

    xfdrv_top #(.HI_HALF(HI_HALF), .LO_HALF(LO_HALF), .DEAD(DEAD)) i_xfdrv_top (
        .clk_i (clk), .rst_ni (rst_n), .enable_i (en), .supply_good_i (sg),
        .mode_hi_i (mode_hi), .phase_a_o (pa), .phase_b_o (pb)
    );

    task automatic check(input string req, input int act, input int exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual %0d expected %0d", req, act, exp);
        end
    endtask

    // R2: continuous overlap monitor
    always @(negedge clk) begin
        if (rst_n && pa === 1'b1 && pb === 1'b1) begin
            errors++;
            $display("FAIL R2 overlap actual 1 expected 0");
        end
    end

    task automatic run_len(input logic wa, input logic wb, output int n);
        n = 0;
        while (pa === wa && pb === wb && n < 5000) begin
            n++;
            @(negedge clk);
        end
    endtask

    task automatic idle_highs(input int cycles, output int highs);
        highs = 0;
        for (int k = 0; k < cycles; k++) begin
            @(negedge clk);
            if (pa !== 1'b0 || pb !== 1'b0) highs++;
        end
    endtask

    initial begin
        int n, g1, g2, nb, hs;
        // R1
        repeat (3) @(negedge clk);
        check("R1 a in reset", int'(pa), 0);
        check("R1 b in reset", int'(pb), 0);
        rst_n = 1'b1;
        idle_highs(10, hs);
        check("R1 idle after reset", hs, 0);

        // table walk: R3 R4 R5 R8 R10
        for (int i = 0; i < 4; i++) begin
            en = 1'b0;
            @(negedge clk);
            mode_hi = VEC[i].mode;
            en = 1'b1;
            sg = 1'b1;
            @(negedge clk);
            check("R8 first phase is A", int'({pa, pb}), 2);
            run_len(1'b1, 1'b0, n);
            check(VEC[i].mode ? "R3 A width" : "R4 A width", n, VEC[i].on_len);
            run_len(1'b0, 1'b0, g1);
            check("R5 gap A to B", g1, VEC[i].gap);
            check("R10 B follows A", int'({pa, pb}), 1);
            run_len(1'b0, 1'b1, nb);
            check(VEC[i].mode ? "R3 B width" : "R4 B width", nb, VEC[i].on_len);
            run_len(1'b0, 1'b0, g2);
            check("R5 gap B to A", g2, VEC[i].gap);
            check("R10 A follows B", int'({pa, pb}), 2);
            check(VEC[i].mode ? "R3 period" : "R4 period", n + g1 + nb + g2, VEC[i].period);
        end

        // R9: mode change inside a high-mode period
        en = 1'b0;
        @(negedge clk);
        mode_hi = 1'b1;
        en = 1'b1;
        @(negedge clk);
        mode_hi = 1'b0;
        run_len(1'b1, 1'b0, n);
        check("R9 current A keeps old width", n, HI_HALF - DEAD);
        run_len(1'b0, 1'b0, g1);
        run_len(1'b0, 1'b1, nb);
        check("R9 current B keeps old width", nb, HI_HALF - DEAD);
        run_len(1'b0, 1'b0, g2);
        run_len(1'b1, 1'b0, n);
        check("R9 next A uses new width", n, LO_HALF - DEAD);

        // R7: supply-good drops while B is high
        run_len(1'b0, 1'b0, g1);
        @(negedge clk);
        sg = 1'b0;
        @(negedge clk);
        check("R7 stop in B", int'({pa, pb}), 0);

        // R6: enable high, supply-good low
        idle_highs(40, hs);
        check("R6 no switching without supply good", hs, 0);

        // R8 restart begins with A, then R7 enable drop while A is high
        sg = 1'b1;
        @(negedge clk);
        check("R8 restart starts with A", int'({pa, pb}), 2);
        repeat (5) @(negedge clk);
        en = 1'b0;
        @(negedge clk);
        check("R7 stop in A", int'({pa, pb}), 0);

        // R6: supply good, enable low
        idle_highs(40, hs);
        check("R6 no switching without enable", hs, 0);

        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog actual 1 expected 0");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule